// File: doc/BRIEF.md
# Serial Segment Frame Receiver

This block accepts display data over a three-wire serial bus made of a burst clock line, a data line and an enable line, and writes the payload into one of two segment latch banks. Bank A drives the segments shown during the first backplane phase and bank B those of the second. All three wires are asynchronous to the system clock. They pass through two-flop synchronizers, and the block works on their edges as seen in the system clock domain.

A frame opens when enable rises. While enable is high, each rising edge of the burst clock takes one data bit. After enable falls, one more burst clock rising edge acts as the load pulse. The block commits the payload on that pulse only if every frame check passed: the first bit was zero, exactly `WORD_BITS` bits arrived, and data never moved while the burst clock was high. Any failure makes the load pulse a no-op, and the receiver is ready for the next frame at once. A successful commit raises a busy flag for `BUSY_CYCLES` system clocks. A frame that opens while busy is high is discarded.

Top module: `seg_frame_rx`

## Requirements
- R1: After reset both segment banks read all zeros and busy is low.
- R2: A frame of exactly WORD_BITS bits has frame bit 0 (sent first) equal to 0 and frame bit WORD_BITS-1 (sent last) equal to 1. When it is followed by one burst clock rising edge with enable low, bank A takes the payload: segment k is frame bit k+1, for k from 0 to WORD_BITS-3. Bank B keeps its value.
- R3: The same frame with its last bit equal to 0 loads bank B, and bank A keeps its value. A single commit never changes both banks.
- R4: A frame whose first bit is 1 leaves both banks unchanged after its load pulse.
- R5: A frame with fewer than WORD_BITS bits (enable dropped early) or more than WORD_BITS bits leaves both banks unchanged after its load pulse.
- R6: A frame in which data changes while the burst clock is high, with enable high, leaves both banks unchanged after its load pulse.
- R7: Banks change only on a load pulse. A valid frame that gets no burst clock edge after enable falls leaves both banks unchanged.
- R8: After a rejected frame, the next valid frame is accepted without any recovery action.
- R9: After a commit, busy stays high for exactly BUSY_CYCLES system clocks. A frame whose enable rises while busy is high does not change either bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial wires |
| rst_n | input | 1 | Active-low asynchronous reset |
| clb_i | input | 1 | Serial burst clock, asynchronous |
| dlen_i | input | 1 | Frame enable, high while bits are sent |
| data_i | input | 1 | Serial data, sampled on the burst clock rising edge |
| bank_a_o | output | WORD_BITS-2 | Segment bank for the first backplane, 1 = segment on |
| bank_b_o | output | WORD_BITS-2 | Segment bank for the second backplane, 1 = segment on |
| busy_o | output | 1 | High for BUSY_CYCLES clocks after a commit |

## Verification
Wrong internal state shows up at the ports in only two ways: a bank that holds the wrong segments, and a busy window of the wrong length. Both appear within three system clocks after the load pulse's burst clock edge reaches the pins. A stale error flag, a miscounted bit or a shift off by one position leaves the banks untouched until that edge arrives. For that reason every frame is followed by a settle time, and both banks are compared against a model that rebuilds the expected payload from the transmitted bits. Rejected frames are mixed in among valid ones, so a flag that fails to clear shows up as a missing update on the frame that follows.

// File: rtl/seg_rx_pkg.sv
package seg_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RECV  = 2'd1,
    ST_ARMED = 2'd2
  } rx_state_t;

  localparam int BANK_A = 0;
  localparam int BANK_B = 1;

  // bank selected by the final frame bit: 1 -> bank A, 0 -> bank B
  function automatic int bank_of(input logic sel_bit);
    return sel_bit ? BANK_A : BANK_B;
  endfunction

  // counter width able to hold word length plus an overflow value
  function automatic int count_width(input int word_bits);
    return $clog2(word_bits + 2);
  endfunction

endpackage

// File: rtl/seg_rx_sync.sv
module seg_rx_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] dly_o
);

  for (genvar i = 0; i < N; i++) begin : g_wire
    logic meta_q, lvl_q, dly_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        lvl_q  <= 1'b0;
        dly_q  <= 1'b0;
      end else begin
        meta_q <= raw_i[i];
        lvl_q  <= meta_q;
        dly_q  <= lvl_q;
      end
    end
    assign lvl_o[i] = lvl_q;
    assign dly_o[i] = dly_q;
  end

endmodule

// File: rtl/seg_rx_shift.sv
module seg_rx_shift #(
  parameter int W  = 22,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          bit_strobe,
  input  logic          data_bit,
  output logic [W-1:0]  word_o,
  output logic [CW-1:0] count_o
);

  localparam logic [CW-1:0] SAT = CW'(W + 1);

  logic [W-1:0]  word_q;
  logic [CW-1:0] count_q;

  // first bit sent ends up in word_q[0] after exactly W shifts
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      count_q <= '0;
    end else if (frame_start) begin
      count_q <= '0;
    end else if (bit_strobe) begin
      word_q <= {data_bit, word_q[W-1:1]};
      if (count_q != SAT) count_q <= count_q + 1'b1;
    end
  end

  assign word_o  = word_q;
  assign count_o = count_q;

endmodule

// File: rtl/seg_rx_ctrl.sv
module seg_rx_ctrl
  import seg_rx_pkg::*;
#(
  parameter int W           = 22,
  parameter int CW          = 5,
  parameter int BUSY_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          frame_end,
  input  logic          bit_strobe,
  input  logic          load_strobe,
  input  logic          data_bit,
  input  logic          data_glitch,
  input  logic [CW-1:0] count_i,
  output logic          load_fire,
  output logic          frame_err,
  output logic          busy_o
);

  localparam int BW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(W);

  rx_state_t     state_q;
  logic          err_q;
  logic [BW-1:0] busy_q;
  logic          busy_now;

  assign busy_now  = (busy_q != '0);
  assign load_fire = (state_q == ST_ARMED) && load_strobe && !err_q
                     && (count_i == FULL) && !busy_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else if (frame_start) begin
      state_q <= ST_RECV;
      err_q   <= busy_now;            // frame opened while busy is discarded
    end else begin
      case (state_q)
        ST_RECV: begin
          if (bit_strobe && count_i == '0 && data_bit) err_q <= 1'b1;
          if (bit_strobe && count_i >= FULL)           err_q <= 1'b1;
          if (data_glitch)                             err_q <= 1'b1;
          if (frame_end) begin
            state_q <= ST_ARMED;
            if (count_i != FULL) err_q <= 1'b1;
          end
        end
        ST_ARMED: if (load_strobe) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            busy_q <= '0;
    else if (load_fire)    busy_q <= BW'(BUSY_CYCLES);
    else if (busy_now)     busy_q <= busy_q - 1'b1;
  end

  assign frame_err = err_q;
  assign busy_o    = busy_now;

endmodule

// File: rtl/seg_rx_banks.sv
module seg_rx_banks
  import seg_rx_pkg::*;
#(
  parameter int SEG = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_fire,
  input  logic           sel_bit,
  input  logic [SEG-1:0] seg_i,
  output logic [SEG-1:0] bank_a_o,
  output logic [SEG-1:0] bank_b_o
);

  logic [SEG-1:0] bank_q [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  bank_q[b] <= '0;
      else if (load_fire && bank_of(sel_bit) == b) bank_q[b] <= seg_i;
    end
  end

  assign bank_a_o = bank_q[BANK_A];
  assign bank_b_o = bank_q[BANK_B];

endmodule

// File: rtl/seg_frame_rx.sv
module seg_frame_rx
  import seg_rx_pkg::*;
#(
  parameter int WORD_BITS   = 22,
  parameter int BUSY_CYCLES = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clb_i,
  input  logic                 dlen_i,
  input  logic                 data_i,
  output logic [WORD_BITS-3:0] bank_a_o,
  output logic [WORD_BITS-3:0] bank_b_o,
  output logic                 busy_o
);

  localparam int SEG_BITS = WORD_BITS - 2;
  localparam int CNT_W    = count_width(WORD_BITS);

  logic [2:0] lvl, dly;
  logic clb_rise, dlen_lvl, frame_start, frame_end;
  logic bit_strobe, load_strobe, data_glitch, data_bit;
  logic load_fire, frame_err;
  logic [WORD_BITS-1:0] frame_word;
  logic [CNT_W-1:0]     bit_count;

  seg_rx_sync #(.N(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .raw_i({data_i, dlen_i, clb_i}),
    .lvl_o(lvl), .dly_o(dly)
  );

  // named events shared by the control, the datapath and the checker
  assign data_bit    = lvl[2];
  assign dlen_lvl    = lvl[1];
  assign clb_rise    = lvl[0] & ~dly[0];
  assign frame_start = lvl[1] & ~dly[1];
  assign frame_end   = ~lvl[1] & dly[1];
  assign bit_strobe  = clb_rise & dlen_lvl;
  assign load_strobe = clb_rise & ~dlen_lvl;
  assign data_glitch = dlen_lvl & lvl[0] & dly[0] & (lvl[2] ^ dly[2]);

  seg_rx_shift #(.W(WORD_BITS), .CW(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .frame_start(frame_start), .bit_strobe(bit_strobe), .data_bit(data_bit),
    .word_o(frame_word), .count_o(bit_count)
  );

  seg_rx_ctrl #(.W(WORD_BITS), .CW(CNT_W), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .frame_start(frame_start), .frame_end(frame_end),
    .bit_strobe(bit_strobe), .load_strobe(load_strobe),
    .data_bit(data_bit), .data_glitch(data_glitch), .count_i(bit_count),
    .load_fire(load_fire), .frame_err(frame_err), .busy_o(busy_o)
  );

  seg_rx_banks #(.SEG(SEG_BITS)) u_banks (
    .clk(clk), .rst_n(rst_n),
    .load_fire(load_fire), .sel_bit(frame_word[WORD_BITS-1]),
    .seg_i(frame_word[WORD_BITS-2:1]),
    .bank_a_o(bank_a_o), .bank_b_o(bank_b_o)
  );

endmodule

// File: rtl/seg_frame_rx_chk.sv
module seg_frame_rx_chk #(
  parameter int SEG = 20
) (
  input logic           clk,
  input logic           rst_n,
  input logic           load_fire,
  input logic           busy,
  input logic           frame_err,
  input logic           data_glitch,
  input logic           frame_start,
  input logic           lead_bit,
  input logic [SEG-1:0] bank_a,
  input logic [SEG-1:0] bank_b
);

  // R7: banks move only in the cycle after a commit
  p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fire |=> ($stable(bank_a) && $stable(bank_b)));

  // R3: a commit touches one bank at most
  p_single_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> ($stable(bank_a) || $stable(bank_b)));

  // R4: a committed frame always began with a zero
  p_lead_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |-> !lead_bit);

  // R9: busy follows every commit
  p_busy_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |=> busy);

  // R6: a data move under a high burst clock marks the frame bad
  p_glitch_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_glitch && !frame_start) |=> frame_err);

endmodule

bind seg_frame_rx seg_frame_rx_chk #(.SEG(WORD_BITS - 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_fire(load_fire), .busy(busy_o),
  .frame_err(frame_err), .data_glitch(data_glitch), .frame_start(frame_start),
  .lead_bit(frame_word[0]), .bank_a(bank_a_o), .bank_b(bank_b_o)
);

// File: tb/seg_frame_rx_test.sv
module seg_frame_rx_test;

  localparam int CLK_PERIOD = 10;
  localparam int W    = 22;
  localparam int SEG  = W - 2;
  localparam int BUSY = 16;
  localparam int HP   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clb = 1'b0, dlen = 1'b0, data = 1'b0;
  logic [SEG-1:0] bank_a, bank_b;
  logic busy;
  logic [SEG-1:0] exp_a = '0, exp_b = '0;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_frame_rx #(.WORD_BITS(W), .BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .clb_i(clb), .dlen_i(dlen), .data_i(data),
    .bank_a_o(bank_a), .bank_b_o(bank_b), .busy_o(busy)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // payload rebuilt from the transmitted order: segment k is the (k+2)-th bit sent
  function automatic logic [SEG-1:0] payload(input logic [63:0] w);
    logic [SEG-1:0] s;
    for (int k = 0; k < SEG; k++) s[k] = w[k+1];
    return s;
  endfunction

  function automatic bit frame_good(input logic [63:0] w, input int nb, input int gl);
    return (nb == W) && (w[0] == 1'b0) && (gl < 0);
  endfunction

  task automatic check_banks(input string tag);
    @(negedge clk);
    chk({tag, " bank A"}, 64'(bank_a), 64'(exp_a));
    chk({tag, " bank B"}, 64'(bank_b), 64'(exp_b));
    tick(1);
  endtask

  task automatic send_frame(input logic [63:0] w, input int nb, input int gl,
                            input bit load, input bit may_accept, input bit settle);
    if (may_accept && load && frame_good(w, nb, gl)) begin
      if (w[W-1]) exp_a = payload(w);
      else        exp_b = payload(w);
    end
    dlen = 1'b1;
    tick(HP);
    for (int i = 0; i < nb; i++) begin
      data = w[i];
      tick(HP);
      clb = 1'b1;
      if (gl == i) begin
        tick(1);
        data = ~data;
        tick(HP - 1);
      end else begin
        tick(HP);
      end
      clb = 1'b0;
      tick(HP);
    end
    dlen = 1'b0;
    tick(HP);
    if (load) begin
      clb = 1'b1;
      tick(HP);
      clb = 1'b0;
      tick(HP);
    end
    if (settle) tick(BUSY + 8);
  endtask

  initial begin
    logic [63:0] w;
    int busy_cnt;
    void'($urandom(32'd2718));
    tick(4);
    @(negedge clk);
    chk("R1 bank A after reset", 64'(bank_a), 64'd0);
    chk("R1 bank B after reset", 64'(bank_b), 64'd0);
    chk("R1 busy after reset", 64'(busy), 64'd0);
    rst_n = 1'b1;
    tick(4);

    w = 64'h0; w[W-1] = 1'b1; w[5:1] = 5'b10110; w[SEG] = 1'b1;
    send_frame(w, W, -1, 1'b1, 1'b1, 1'b1);
    check_banks("R2 select high");

    w = 64'h0015_5AA6; w[0] = 1'b0; w[W-1] = 1'b0;
    send_frame(w, W, -1, 1'b1, 1'b1, 1'b1);
    check_banks("R3 select low");

    w = 64'h003F_FFFF;
    send_frame(w, W, -1, 1'b1, 1'b1, 1'b1);
    check_banks("R4 leading one");

    w = 64'h0024_9248;
    send_frame(w, W - 1, -1, 1'b1, 1'b1, 1'b1);
    check_banks("R5 short frame");
    send_frame(w, W + 1, -1, 1'b1, 1'b1, 1'b1);
    check_banks("R5 long frame");

    send_frame(w, W, 7, 1'b1, 1'b1, 1'b1);
    check_banks("R6 data glitch");

    send_frame(w, W, -1, 1'b0, 1'b1, 1'b1);
    check_banks("R7 no load pulse");

    w = 64'h0013_3331;
    send_frame(w, W, -1, 1'b1, 1'b1, 1'b0);
    w = 64'h0033_3332;
    send_frame(w, W, -1, 1'b1, 1'b1, 1'b1);
    check_banks("R8 accept after reject");

    // R9: busy window length, measured from the load pulse
    w = 64'h0000_0F0E; w[W-1] = 1'b1;
    send_frame(w, W, -1, 1'b0, 1'b1, 1'b0);
    exp_a = payload(w);
    clb = 1'b1;
    busy_cnt = 0;
    for (int c = 0; c < BUSY + 12; c++) begin
      @(negedge clk);
      if (busy) busy_cnt++;
      if (c == HP) clb = 1'b0;
    end
    chk("R9 busy length", 64'(busy_cnt), 64'(BUSY));
    tick(2);
    check_banks("R9 load by late pulse");

    // R9: frame opened while busy is discarded
    w = 64'h0000_00F0; w[W-1] = 1'b0;
    send_frame(w, W, -1, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    chk("R9 busy at next frame", 64'(busy), 64'd1);
    w = 64'h0012_3456; w[0] = 1'b0;
    send_frame(w, W, -1, 1'b1, 1'b0, 1'b1);
    check_banks("R9 frame during busy");

    for (int n = 0; n < 50; n++) begin
      int kind, nb, gl;
      bit ld;
      w = {$urandom, $urandom};
      w[0] = 1'b0;
      nb = W; gl = -1; ld = 1'b1;
      kind = $urandom % 8;
      case (kind)
        0: w[0] = 1'b1;
        1: nb = W - 1 - int'($urandom % 3);
        2: nb = W + 1 + int'($urandom % 2);
        3: gl = int'($urandom % W);
        4: ld = 1'b0;
        default: ;
      endcase
      send_frame(w, nb, gl, ld, 1'b1, 1'b1);
      check_banks("R2/R3 random mix R8");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule